// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a processor that reports what it is doing through a three-bit status code instead of driving bus strobes itself. When the code leaves the passive value, the block starts a bus cycle and walks it through the T1, T2, T3, optional wait and T4 states, one clock each. In each state it drives the address latch strobe, the data transceiver enable and direction, and the active-low memory, IO and interrupt-acknowledge commands for the decoded cycle type.

Writes have two command flavours. The advanced strobe opens one state earlier than the normal strobe. A command-enable input can suppress all commands, and a release input hands the command lines to another bus master. One output changes meaning with the IO-bus mode input: it is a cascade enable for an interrupt controller in one mode and a peripheral data enable in the other.

All outputs are registered. Each one reflects the state entered at a rising edge, together with the control inputs sampled at that same edge.

Top module: `bus_cmd_gen`

## Requirements
- R1: While `rst` is high, at each rising edge the outputs go to their idle values: `addr_latch`=0, `xcvr_en`=0, `xcvr_dir`=1, all seven command outputs = 1, `casc_pden`=0, `cmd_oe`=1.
- R2: Status codes are 000 acknowledge, 001 IO read, 010 IO write, 011 halt, 100 fetch, 101 memory read, 110 memory write, 111 passive. A cycle starts only when the block is idle, the code held at the previous edge was 111 and the current code is neither 111 nor 011. Halt and passive start nothing.
- R3: `addr_latch` is high for exactly the T1 state. `xcvr_dir` is 0 from T1 through T4 for codes 000, 001, 100 and 101, and is 1 otherwise.
- R4: `mem_rd_n` (codes 100 and 101), `io_rd_n` (001) and `int_ack_n` (000) are low in T2, T3 and every wait state, and high again in T4.
- R5: For writes, the advanced strobe (`mem_wr_adv_n` for 110, `io_wr_adv_n` for 010) is low from T2. The normal strobe (`mem_wr_n`, `io_wr_n`) is low from T3. Both are high again in T4.
- R6: `xcvr_en` is high in T2, T3 and wait states of every started cycle, and low elsewhere.
- R7: At the edge that leaves T3 or a wait state, `ready` low inserts another wait state and `ready` high moves to T4. The command pulse therefore lasts two cycles plus one per wait state.
- R8: `cmd_en` low at an edge forces `xcvr_en` low and all command outputs high after that edge.
- R9: `cmd_release` high at an edge forces `cmd_oe` low and all command outputs high after that edge. `xcvr_en` is unaffected.
- R10: With `iobus_mode`=0, `casc_pden` is high during T1 of an acknowledge cycle. With `iobus_mode`=1, it is low while `xcvr_en` is high for codes 000, 001 and 010, and high otherwise.
- R11: Each acknowledge cycle gives one `int_ack_n` pulse, so two back-to-back acknowledge cycles give two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| status_in | input | 3 | Processor status code |
| ready | input | 1 | Slave ready, sampled at the end of T3 and wait states |
| cmd_en | input | 1 | Command enable |
| cmd_release | input | 1 | Releases command lines to another master |
| iobus_mode | input | 1 | Selects the meaning of `casc_pden` |
| addr_latch | output | 1 | Address latch strobe |
| xcvr_en | output | 1 | Data transceiver enable |
| xcvr_dir | output | 1 | Transceiver direction, 0 = toward processor |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| mem_wr_adv_n | output | 1 | Advanced memory write command |
| io_rd_n | output | 1 | IO read command |
| io_wr_n | output | 1 | IO write command |
| io_wr_adv_n | output | 1 | Advanced IO write command |
| int_ack_n | output | 1 | Interrupt acknowledge |
| casc_pden | output | 1 | Cascade enable or peripheral data enable |
| cmd_oe | output | 1 | Command line drive enable |

## Verification
A new status code applied before edge k produces T1 outputs right after edge k. T2, T3, the wait states and T4 follow at edges k+1, k+2, k+3 onward, and `ready` is consulted at edge k+2+j for the j-th wait decision. Control inputs take effect one edge after they are applied, because every output is registered. The bench therefore drives all inputs at the falling edge, advances one rising edge, and compares every output at the following falling edge against a per-state value computed from the code, the wait count and the control inputs. Pulse lengths and pulse counts are tallied over each cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_ACK   = 3'b000,
    ST_IORD  = 3'b001,
    ST_IOWR  = 3'b010,
    ST_HALT  = 3'b011,
    ST_FETCH = 3'b100,
    ST_MRD   = 3'b101,
    ST_MWR   = 3'b110,
    ST_PASS  = 3'b111
  } stat_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_T3,
    PH_TW,
    PH_T4
  } phase_e;

  typedef struct packed {
    logic rd_mem;
    logic rd_io;
    logic wr_mem;
    logic wr_io;
    logic ack;
  } kind_t;
endpackage

// File: rtl/bcg_decode.sv
module bcg_decode
  import bcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  output logic              start,
  output kind_t             kind
);
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= ST_PASS;
    else     stat_q <= stat;
  end

  assign start = (stat_q == ST_PASS) && (stat != ST_PASS) && (stat != ST_HALT);

  always_comb begin
    kind = '0;
    case (stat)
      ST_ACK:   kind.ack    = 1'b1;
      ST_IORD:  kind.rd_io  = 1'b1;
      ST_IOWR:  kind.wr_io  = 1'b1;
      ST_FETCH: kind.rd_mem = 1'b1;
      ST_MRD:   kind.rd_mem = 1'b1;
      ST_MWR:   kind.wr_mem = 1'b1;
      default:  kind = '0;
    endcase
  end

  // R2: a start never comes from a kind-less code
  a_r2_start_has_kind: assert property (@(posedge clk) disable iff (rst)
    start |-> ($countones(kind) == 1));
endmodule

// File: rtl/bcg_phase.sv
module bcg_phase
  import bcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   ready,
  input  kind_t  kind_in,
  output phase_e phase_d,
  output kind_t  kind_d
);
  phase_e phase_q;
  kind_t  kind_q;

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_T1;
        kind_d  = kind_in;
      end
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3,
      PH_TW:   phase_d = ready ? PH_T4 : PH_TW;
      PH_T4:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      kind_q  <= '0;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
    end
  end

  // R7: a wait state persists until ready is seen
  a_r7_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_TW && !ready) |=> (phase_q == PH_TW));
  // R2: an idle block with no start stays idle
  a_r2_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !start) |=> (phase_q == PH_IDLE));
  // R3: T1 always leads to T2
  a_r3_t1_to_t2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_T1) |=> (phase_q == PH_T2));
endmodule

// File: rtl/bcg_outgen.sv
module bcg_outgen
  import bcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_d,
  input  kind_t  kind_d,
  input  logic   cmd_en,
  input  logic   cmd_release,
  input  logic   iobus_mode,
  output logic   addr_latch,
  output logic   xcvr_en,
  output logic   xcvr_dir,
  output logic   mem_rd_n,
  output logic   mem_wr_n,
  output logic   mem_wr_adv_n,
  output logic   io_rd_n,
  output logic   io_wr_n,
  output logic   io_wr_adv_n,
  output logic   int_ack_n,
  output logic   casc_pden,
  output logic   cmd_oe
);
  logic act, late, busy, rd, gate, io_cyc;

  always_comb begin
    act    = (phase_d == PH_T2) || (phase_d == PH_T3) || (phase_d == PH_TW);
    late   = (phase_d == PH_T3) || (phase_d == PH_TW);
    busy   = (phase_d != PH_IDLE);
    rd     = kind_d.rd_mem | kind_d.rd_io | kind_d.ack;
    io_cyc = kind_d.rd_io | kind_d.wr_io | kind_d.ack;
    gate   = cmd_en && !cmd_release;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_latch   <= 1'b0;
      xcvr_en      <= 1'b0;
      xcvr_dir     <= 1'b1;
      mem_rd_n     <= 1'b1;
      mem_wr_n     <= 1'b1;
      mem_wr_adv_n <= 1'b1;
      io_rd_n      <= 1'b1;
      io_wr_n      <= 1'b1;
      io_wr_adv_n  <= 1'b1;
      int_ack_n    <= 1'b1;
      casc_pden    <= 1'b0;
      cmd_oe       <= 1'b1;
    end else begin
      addr_latch   <= (phase_d == PH_T1);
      xcvr_en      <= act && cmd_en;
      xcvr_dir     <= !(busy && rd);
      mem_rd_n     <= !(act  && kind_d.rd_mem && gate);
      mem_wr_adv_n <= !(act  && kind_d.wr_mem && gate);
      mem_wr_n     <= !(late && kind_d.wr_mem && gate);
      io_rd_n      <= !(act  && kind_d.rd_io  && gate);
      io_wr_adv_n  <= !(act  && kind_d.wr_io  && gate);
      io_wr_n      <= !(late && kind_d.wr_io  && gate);
      int_ack_n    <= !(act  && kind_d.ack    && gate);
      casc_pden    <= iobus_mode ? !(act && cmd_en && io_cyc)
                                 : ((phase_d == PH_T1) && kind_d.ack);
      cmd_oe       <= !cmd_release;
    end
  end

  // R3: the latch strobe lasts a single cycle
  a_r3_ale_single: assert property (@(posedge clk) disable iff (rst)
    addr_latch |=> !addr_latch);
  // R5: a normal write is always covered by its advanced write
  a_r5_mem_wr_covered: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> !mem_wr_adv_n);
  a_r5_io_wr_covered: assert property (@(posedge clk) disable iff (rst)
    !io_wr_n |-> !io_wr_adv_n);
  // R4: at most one command family active
  a_r4_one_cmd: assert property (@(posedge clk) disable iff (rst)
    $countones({~mem_rd_n, ~mem_wr_adv_n, ~io_rd_n, ~io_wr_adv_n, ~int_ack_n}) <= 1);
  // R8: command enable off silences everything
  a_r8_cen_off: assert property (@(posedge clk) disable iff (rst)
    !cmd_en |=> (!xcvr_en && mem_rd_n && mem_wr_adv_n && io_rd_n && io_wr_adv_n && int_ack_n));
  // R9: release drops the drive enable and the commands
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    cmd_release |=> (!cmd_oe && mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && int_ack_n));
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] status_in,
  input  logic              ready,
  input  logic              cmd_en,
  input  logic              cmd_release,
  input  logic              iobus_mode,
  output logic              addr_latch,
  output logic              xcvr_en,
  output logic              xcvr_dir,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              mem_wr_adv_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              io_wr_adv_n,
  output logic              int_ack_n,
  output logic              casc_pden,
  output logic              cmd_oe
);
  logic   start;
  kind_t  kind_now;
  phase_e phase_d;
  kind_t  kind_d;

  bcg_decode u_dec (
    .clk(clk), .rst(rst), .stat(status_in), .start(start), .kind(kind_now)
  );

  bcg_phase u_ph (
    .clk(clk), .rst(rst), .start(start), .ready(ready), .kind_in(kind_now),
    .phase_d(phase_d), .kind_d(kind_d)
  );

  bcg_outgen u_out (
    .clk(clk), .rst(rst), .phase_d(phase_d), .kind_d(kind_d),
    .cmd_en(cmd_en), .cmd_release(cmd_release), .iobus_mode(iobus_mode),
    .addr_latch(addr_latch), .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wr_adv_n(mem_wr_adv_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wr_adv_n(io_wr_adv_n),
    .int_ack_n(int_ack_n), .casc_pden(casc_pden), .cmd_oe(cmd_oe)
  );
endmodule

// File: tb/bus_cmd_gen_test.sv
module bus_cmd_gen_test;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] status_in = 3'b111;
  logic ready = 1'b1, cmd_en = 1'b1, cmd_release = 1'b0, iobus_mode = 1'b0;
  logic addr_latch, xcvr_en, xcvr_dir, mem_rd_n, mem_wr_n, mem_wr_adv_n;
  logic io_rd_n, io_wr_n, io_wr_adv_n, int_ack_n, casc_pden, cmd_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bus_cmd_gen uut (
    .clk(clk), .rst(rst), .status_in(status_in), .ready(ready), .cmd_en(cmd_en),
    .cmd_release(cmd_release), .iobus_mode(iobus_mode), .addr_latch(addr_latch),
    .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_wr_adv_n(mem_wr_adv_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .io_wr_adv_n(io_wr_adv_n), .int_ack_n(int_ack_n), .casc_pden(casc_pden), .cmd_oe(cmd_oe)
  );

  wire [11:0] outv = {addr_latch, xcvr_en, xcvr_dir, mem_rd_n, mem_wr_n, mem_wr_adv_n,
                      io_rd_n, io_wr_n, io_wr_adv_n, int_ack_n, casc_pden, cmd_oe};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
  function automatic logic [11:0] expv(int ph, logic [2:0] code, bit iob, bit cen, bit rel);
    logic [11:0] e;
    bit act  = (ph == 2) || (ph == 3) || (ph == 4);
    bit late = (ph == 3) || (ph == 4);
    bit busy = (ph != 0);
    bit rm = (code == 3'd4) || (code == 3'd5);
    bit ri = (code == 3'd1), wm = (code == 3'd6), wi = (code == 3'd2), ak = (code == 3'd0);
    bit g = cen && !rel;
    e[11] = (ph == 1);
    e[10] = act && cen;
    e[9]  = !(busy && (rm || ri || ak));
    e[8]  = !(act && rm && g);
    e[7]  = !(late && wm && g);
    e[6]  = !(act && wm && g);
    e[5]  = !(act && ri && g);
    e[4]  = !(late && wi && g);
    e[3]  = !(act && wi && g);
    e[2]  = !(act && ak && g);
    e[1]  = iob ? !(act && cen && (ri || wi || ak)) : ((ph == 1) && ak);
    e[0]  = !rel;
    return e;
  endfunction

  task automatic compare_all(input string ctx, input logic [11:0] e);
    chk({ctx, " R3 latch/dir"}, outv & 12'hA00, e & 12'hA00);
    chk({ctx, " R4 read/ack"},  outv & 12'h124, e & 12'h124);
    chk({ctx, " R5 writes"},    outv & 12'h0D8, e & 12'h0D8);
    chk({ctx, " R6 xcvr_en"},   outv & 12'h400, e & 12'h400);
    chk({ctx, " R10 casc"},     outv & 12'h002, e & 12'h002);
    chk({ctx, " R9 oe"},        outv & 12'h001, e & 12'h001);
  endtask

  task automatic run_cycle(input logic [2:0] code, input int w, input bit iob, input bit cen,
                           input bit rel, input string ctx, output int pulses);
    bit starts = !((code == 3'd3) || (code == 3'd7));
    int n_ale = 0, n_cmd = 0, ph;
    logic prev_ack = 1'b1;
    pulses = 0;
    iobus_mode = iob; cmd_en = cen; cmd_release = rel; status_in = 3'b111; ready = 1'b1;
    step();
    compare_all({ctx, " idle"}, expv(0, code, iob, cen, rel));
    status_in = code;
    for (int e = 0; e <= 4 + w; e++) begin
      ready = (e < 3) ? 1'b1 : ((e - 3) >= w);
      if (e == 2) status_in = 3'b111;
      step();
      if (!starts)         ph = 0;
      else if (e == 0)     ph = 1;
      else if (e == 1)     ph = 2;
      else if (e == 2)     ph = 3;
      else if (e <= 2 + w) ph = 4;
      else if (e == 3 + w) ph = 5;
      else                 ph = 0;
      compare_all(ctx, expv(ph, code, iob, cen, rel));
      if (addr_latch) n_ale++;
      if (!(mem_rd_n && mem_wr_adv_n && io_rd_n && io_wr_adv_n && int_ack_n)) n_cmd++;
      if (prev_ack && !int_ack_n) pulses++;
      prev_ack = int_ack_n;
    end
    chk({ctx, " R2 start count"}, n_ale, starts ? 1 : 0);
    chk({ctx, " R7 pulse length"}, n_cmd, (starts && cen && !rel) ? (w + 2) : 0);
  endtask

  initial begin
    int p1, p2;
    rst = 1'b1;
    step(); step();
    // R1: reset values
    chk("R1 reset outputs", outv, 12'b0011_1111_1101);
    rst = 1'b0;
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 3; w++)
        for (int iob = 0; iob < 2; iob++) begin
          run_cycle(3'(c), w, iob[0], 1'b1, 1'b0, "sweep", p1);
          run_cycle(3'(c), w, iob[0], 1'b0, 1'b0, "R8 cen_off", p1);
          run_cycle(3'(c), w, iob[0], 1'b1, 1'b1, "R9 release", p1);
        end
    // R11: two back-to-back acknowledge cycles, two pulses
    run_cycle(3'd0, 0, 1'b0, 1'b1, 1'b0, "R11 ack1", p1);
    run_cycle(3'd0, 1, 1'b0, 1'b1, 1'b0, "R11 ack2", p2);
    chk("R11 ack pulse total", p1 + p2, 2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule